// File: doc/BRIEF.md
# Three-Bus Processor Datapath

This block is the data side of a simple processor built around three buses. Two source buses, A and B, are fed by a register file with two read ports, and a single result bus, C, carries the ALU output back to every register that can be loaded. A register-to-register operation with three operands therefore finishes in one step. The block also holds the program counter with an incrementer of its own, the memory address register, the memory data register and the instruction register.

A sequencer outside the block supplies the full set of control lines for every clock step. No instruction decode happens inside the block. A typical fetch takes three steps. In the first step the PC is placed on bus B, passes through the ALU unchanged into the address register, a read starts and the PC advances. In the second step the sequencer waits on the memory handshake and captures the read word. In the third step the captured word moves over bus B into the instruction register.

The memory side has a request flag that stays set until the memory answers with a one-cycle done pulse. While the sequencer waits for read data, a stall output tells it to hold the current step.

Top module: `tbus_datapath`

## Requirements
- R1: After reset the PC equals RESET_PC (default 0). The address register, the data register, the instruction register and every register-file entry are zero. No memory request is pending and stall is low.
- R2: With bsel=1 (PC on bus B) and alu_op=0 (pass bus B), bus C equals the PC in the same cycle. If mar_ld and pc_inc are set in that step, then after the edge mem_addr holds the old PC and the PC has advanced by PC_STEP (default 4).
- R3: mem_rd or mem_wr sets mem_req at the next edge, and mem_req stays set until a cycle with mem_done. mem_we is 0 for a read. While mdr_ld_mem is high and mem_done is low, stall is high and the data register keeps its value. In the cycle where mdr_ld_mem and mem_done are both high, stall is low and mem_rdata is captured.
- R4: With bsel=2 (data register on bus B), alu_op=0 and ir_ld set, the instruction register takes the data register's value at the edge. The same bus C value may also be written to register rc_idx.
- R5: With alu_op=1, bus C = bus A + bus B modulo 2^DW, where bus A is entry ra_idx and bus B is entry rb_idx (bsel=0). With rc_we set, the sum lands in entry rc_idx at the end of that single step.
- R6: alu_op 2 gives A-B, 3 gives A AND B, 4 gives A OR B and 5 gives A XOR B. Codes 6 and 7 pass bus B unchanged.
- R7: Both read ports address entries independently in the same cycle. When rc_idx equals a source index, the operation uses the old value and the new value is visible from the next cycle.
- R8: When pc_ld and pc_inc are set together, the PC loads bus C and the increment is dropped. bsel=3 drives the instruction register onto bus B.
- R9: mem_wr, issued together with mar_ld, starts a write with mem_we=1 at the address taken from bus C. mem_wdata is the data register, which mdr_ld_c loads from bus C. The request clears after mem_done.
- R10: With rc_we low, no register-file entry changes, whatever rc_idx holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ra_idx | input | RIDX | Read port index for bus A |
| rb_idx | input | RIDX | Read port index for bus B |
| rc_idx | input | RIDX | Write index from bus C |
| rc_we | input | 1 | Register-file write enable |
| bsel | input | 2 | Bus B source: 0 register, 1 PC, 2 data reg, 3 instruction reg |
| alu_op | input | 3 | ALU operation code |
| pc_inc | input | 1 | Advance PC by PC_STEP |
| pc_ld | input | 1 | Load PC from bus C (wins over pc_inc) |
| mar_ld | input | 1 | Load address register from bus C |
| ir_ld | input | 1 | Load instruction register from bus C |
| mdr_ld_c | input | 1 | Load data register from bus C |
| mdr_ld_mem | input | 1 | Wait for and capture read data |
| mem_rd | input | 1 | Start a memory read |
| mem_wr | input | 1 | Start a memory write |
| mem_rdata | input | DW | Read data from memory |
| mem_done | input | 1 | Memory completion pulse |
| mem_addr | output | DW | Address register contents |
| mem_wdata | output | DW | Data register contents |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| stall | output | 1 | Step must repeat, read data not yet there |
| pc_q | output | DW | Program counter |
| ir_q | output | DW | Instruction register |
| bus_c | output | DW | Result bus |

## Verification
The properties assume the memory raises mem_done only while mem_req is set. They also assume that no new read or write is started while one is pending, and that mem_rd and mem_wr are never high together. The bench plays the memory itself. It drives mem_done in exactly one step per access, after the request flag is already set, and it issues each access from a step in which nothing else is outstanding. It pre-loads no registers by hidden means. Every register value enters through fetch steps that read words from the bench's memory image.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

   typedef enum logic [2:0] {
      ALU_PASS_B = 3'd0,
      ALU_ADD    = 3'd1,
      ALU_SUB    = 3'd2,
      ALU_AND    = 3'd3,
      ALU_OR     = 3'd4,
      ALU_XOR    = 3'd5,
      ALU_RSV6   = 3'd6,
      ALU_RSV7   = 3'd7
   } alu_op_e;

   typedef enum logic [1:0] {
      BSRC_REG = 2'd0,
      BSRC_PC  = 2'd1,
      BSRC_MDR = 2'd2,
      BSRC_IR  = 2'd3
   } bsrc_e;

endpackage

// File: rtl/tbus_regfile.sv
module tbus_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 8,
   localparam int RIDX = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RIDX-1:0] ra,
   input  logic [RIDX-1:0] rb,
   input  logic [RIDX-1:0] rc,
   input  logic            we,
   input  logic [DW-1:0]   wd,
   output logic [DW-1:0]   rda,
   output logic [DW-1:0]   rdb
);

   logic [DW-1:0] ent [NREG];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && (rc == RIDX'(gi)))
            q <= wd;
      end
      assign ent[gi] = q;
   end

   // combinational read ports: a write at this edge is seen next cycle
   assign rda = ent[ra];
   assign rdb = ent[rb];

endmodule

// File: rtl/tbus_alu.sv
module tbus_alu import tbus_pkg::*; #(
   parameter int DW = 32
) (
   input  alu_op_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);

   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_XOR: y = a ^ b;
         default: y = b;
      endcase
   end

endmodule

// File: rtl/tbus_pc.sv
module tbus_pc #(
   parameter int          DW       = 32,
   parameter int          PC_STEP  = 4,
   parameter int unsigned RESET_PC = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          ld,
   input  logic [DW-1:0] ld_val,
   output logic [DW-1:0] pc
);

   localparam int  SL     = $clog2(PC_STEP);
   localparam bit  IS_P2  = ((1 << SL) == PC_STEP) && (SL > 0);

   logic [DW-1:0] pc_next_seq;

   if (IS_P2) begin : g_p2
      // low bits never change: add one to the upper slice only
      assign pc_next_seq = {pc[DW-1:SL] + 1'b1, pc[SL-1:0]};
   end else begin : g_any
      assign pc_next_seq = pc + DW'(PC_STEP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= DW'(RESET_PC);
      else if (ld)
         pc <= ld_val;
      else if (inc)
         pc <= pc_next_seq;
   end

endmodule

// File: rtl/tbus_datapath.sv
module tbus_datapath import tbus_pkg::*; #(
   parameter int          DW       = 32,
   parameter int          NREG     = 8,
   parameter int          PC_STEP  = 4,
   parameter int unsigned RESET_PC = 0,
   localparam int         RIDX     = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RIDX-1:0] ra_idx,
   input  logic [RIDX-1:0] rb_idx,
   input  logic [RIDX-1:0] rc_idx,
   input  logic            rc_we,
   input  logic [1:0]      bsel,
   input  logic [2:0]      alu_op,
   input  logic            pc_inc,
   input  logic            pc_ld,
   input  logic            mar_ld,
   input  logic            ir_ld,
   input  logic            mdr_ld_c,
   input  logic            mdr_ld_mem,
   input  logic            mem_rd,
   input  logic            mem_wr,
   input  logic [DW-1:0]   mem_rdata,
   input  logic            mem_done,
   output logic [DW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic            mem_req,
   output logic            mem_we,
   output logic            stall,
   output logic [DW-1:0]   pc_q,
   output logic [DW-1:0]   ir_q,
   output logic [DW-1:0]   bus_c
);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("tbus_datapath: NREG must be a power of two of at least 2");
   end
   if (PC_STEP < 1) begin : g_bad_step
      $error("tbus_datapath: PC_STEP must be positive");
   end
   if (DW < 8) begin : g_bad_dw
      $error("tbus_datapath: DW must be at least 8");
   end

   logic [DW-1:0] bus_a;
   logic [DW-1:0] bus_b;
   logic [DW-1:0] rf_b;
   logic [DW-1:0] mar_q;
   logic [DW-1:0] mdr_q;

   tbus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk (clk),
      .rst_n (rst_n),
      .ra  (ra_idx),
      .rb  (rb_idx),
      .rc  (rc_idx),
      .we  (rc_we),
      .wd  (bus_c),
      .rda (bus_a),
      .rdb (rf_b)
   );

   always_comb begin
      unique case (bsrc_e'(bsel))
         BSRC_PC:  bus_b = pc_q;
         BSRC_MDR: bus_b = mdr_q;
         BSRC_IR:  bus_b = ir_q;
         default:  bus_b = rf_b;
      endcase
   end

   tbus_alu #(.DW(DW)) u_alu (
      .op (alu_op_e'(alu_op)),
      .a  (bus_a),
      .b  (bus_b),
      .y  (bus_c)
   );

   tbus_pc #(.DW(DW), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (pc_inc),
      .ld     (pc_ld),
      .ld_val (bus_c),
      .pc     (pc_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar_q <= '0;
         ir_q  <= '0;
         mdr_q <= '0;
      end else begin
         if (mar_ld) mar_q <= bus_c;
         if (ir_ld)  ir_q  <= bus_c;
         if (mdr_ld_mem && mem_done)
            mdr_q <= mem_rdata;
         else if (mdr_ld_c)
            mdr_q <= bus_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req <= 1'b0;
         mem_we  <= 1'b0;
      end else if (mem_rd || mem_wr) begin
         mem_req <= 1'b1;
         mem_we  <= mem_wr;
      end else if (mem_done) begin
         mem_req <= 1'b0;
         mem_we  <= 1'b0;
      end
   end

   assign stall     = mdr_ld_mem & ~mem_done;
   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;

endmodule

// File: rtl/tbus_checker.sv
module tbus_checker #(
   parameter int DW      = 32,
   parameter int PC_STEP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pc_inc,
   input logic          pc_ld,
   input logic          mar_ld,
   input logic          ir_ld,
   input logic          mdr_ld_c,
   input logic          mdr_ld_mem,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic          mem_done,
   input logic          mem_req,
   input logic [2:0]    alu_op,
   input logic [DW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic [DW-1:0] pc_q,
   input logic [DW-1:0] ir_q,
   input logic [DW-1:0] bus_b,
   input logic [DW-1:0] bus_c
);

   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pc_inc && !pc_ld |=> pc_q == $past(pc_q) + DW'(PC_STEP));

   p_mar_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mar_ld |=> mem_addr == $past(bus_c));

   p_mdr_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mdr_ld_mem && !mem_done && !mdr_ld_c |=> $stable(mem_wdata));

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_done |=> mem_req);

   p_ir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ir_ld |=> ir_q == $past(bus_c));

   p_pass_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      alu_op == 3'd0 |-> bus_c == bus_b);

   p_pc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pc_ld |=> pc_q == $past(bus_c));

   p_req_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_done && !mem_rd && !mem_wr |=> !mem_req);

   // input assumption: completion only answers a pending access
   p_done_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_done |-> mem_req);

endmodule

bind tbus_datapath tbus_checker #(.DW(DW), .PC_STEP(PC_STEP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pc_inc     (pc_inc),
   .pc_ld      (pc_ld),
   .mar_ld     (mar_ld),
   .ir_ld      (ir_ld),
   .mdr_ld_c   (mdr_ld_c),
   .mdr_ld_mem (mdr_ld_mem),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .mem_done   (mem_done),
   .mem_req    (mem_req),
   .alu_op     (alu_op),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .pc_q       (pc_q),
   .ir_q       (ir_q),
   .bus_b      (bus_b),
   .bus_c      (bus_c)
);

// File: tb/sim_tbus_datapath.sv
`timescale 1ns/1ps
module sim_tbus_datapath;
   localparam int DW = 32;
   localparam int RIDX = 3;
   localparam int S_PC = 0, S_MAR = 1, S_MDR = 2, S_IR = 3, S_BUSC = 4,
                  S_STALL = 5, S_REQ = 6, S_WE = 7;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n;
   logic [RIDX-1:0] ra_idx, rb_idx, rc_idx;
   logic rc_we, pc_inc, pc_ld, mar_ld, ir_ld, mdr_ld_c, mdr_ld_mem, mem_rd, mem_wr, mem_done;
   logic [1:0] bsel;
   logic [2:0] alu_op;
   logic [DW-1:0] mem_rdata, mem_addr, mem_wdata, pc_q, ir_q, bus_c;
   logic mem_req, mem_we, stall;

   // shadow controls, copied to the pins at the falling edge
   logic [RIDX-1:0] s_ra, s_rb, s_rc;
   logic s_we, s_inc, s_pld, s_mar, s_ir, s_mdrc, s_mdrm, s_rd, s_wr, s_done;
   logic [1:0] s_bsel;
   logic [2:0] s_op;

   logic [DW-1:0] mem_w [16];
   logic [DW-1:0] rexp [8];
   logic [DW-1:0] pc_e, mdr_e;
   assign mem_rdata = mem_w[mem_addr[5:2]];

   tbus_datapath u0 (
      .clk(clk), .rst_n(rst_n), .ra_idx(ra_idx), .rb_idx(rb_idx), .rc_idx(rc_idx),
      .rc_we(rc_we), .bsel(bsel), .alu_op(alu_op), .pc_inc(pc_inc), .pc_ld(pc_ld),
      .mar_ld(mar_ld), .ir_ld(ir_ld), .mdr_ld_c(mdr_ld_c), .mdr_ld_mem(mdr_ld_mem),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_done(mem_done),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .stall(stall), .pc_q(pc_q), .ir_q(ir_q), .bus_c(bus_c));

   typedef struct { int at; int sig; logic [DW-1:0] val; string tag; } item_t;
   item_t q[$];
   int cyc = 0, now = 0, n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   function automatic logic [DW-1:0] obs(int sig);
      case (sig)
         S_PC:    return pc_q;
         S_MAR:   return mem_addr;
         S_MDR:   return mem_wdata;
         S_IR:    return ir_q;
         S_BUSC:  return bus_c;
         S_STALL: return {{(DW-1){1'b0}}, stall};
         S_REQ:   return {{(DW-1){1'b0}}, mem_req};
         default: return {{(DW-1){1'b0}}, mem_we};
      endcase
   endfunction

   // monitor: samples one time unit after each falling edge
   initial forever begin
      item_t keep[$];
      @(negedge clk);
      #1;
      cyc++;
      keep = {};
      foreach (q[i]) begin
         if (q[i].at == cyc) begin
            n_chk++;
            if (obs(q[i].sig) !== q[i].val) begin
               n_fail++;
               $display("FAIL %s sig%0d actual %h expected %h (cycle %0d)",
                        q[i].tag, q[i].sig, obs(q[i].sig), q[i].val, cyc);
            end
         end else begin
            keep.push_back(q[i]);
         end
      end
      q = keep;
   end

   task automatic clr();
      s_ra = '0; s_rb = '0; s_rc = '0; s_we = 0; s_inc = 0; s_pld = 0; s_mar = 0;
      s_ir = 0; s_mdrc = 0; s_mdrm = 0; s_rd = 0; s_wr = 0; s_done = 0;
      s_bsel = 2'd0; s_op = 3'd0;
   endtask

   task automatic go();
      @(negedge clk);
      ra_idx = s_ra; rb_idx = s_rb; rc_idx = s_rc; rc_we = s_we; pc_inc = s_inc;
      pc_ld = s_pld; mar_ld = s_mar; ir_ld = s_ir; mdr_ld_c = s_mdrc;
      mdr_ld_mem = s_mdrm; mem_rd = s_rd; mem_wr = s_wr; mem_done = s_done;
      bsel = s_bsel; alu_op = s_op;
      now = cyc + 1;
   endtask

   // driver side of the scoreboard: off 0 = this step, 1 = after its edge
   task automatic expect_v(int off, int sig, logic [DW-1:0] v, string tag);
      item_t it;
      it.at = now + off; it.sig = sig; it.val = v; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic fetch_to(int k);
      logic [DW-1:0] word;
      word = mem_w[pc_e[5:2]];
      clr(); s_bsel = 2'd1; s_mar = 1; s_inc = 1; s_rd = 1; go();
      expect_v(0, S_BUSC, pc_e, "R2");
      expect_v(1, S_MAR, pc_e, "R2");
      expect_v(1, S_PC, pc_e + 4, "R2");
      expect_v(1, S_REQ, 1, "R3");
      expect_v(1, S_WE, 0, "R3");
      pc_e = pc_e + 4;
      clr(); s_mdrm = 1; go();
      expect_v(0, S_STALL, 1, "R3");
      expect_v(1, S_REQ, 1, "R3");
      expect_v(1, S_MDR, mdr_e, "R3");
      clr(); s_mdrm = 1; s_done = 1; go();
      expect_v(0, S_STALL, 0, "R3");
      expect_v(1, S_REQ, 0, "R3");
      expect_v(1, S_MDR, word, "R3");
      mdr_e = word;
      clr(); s_bsel = 2'd2; s_ir = 1; s_rc = RIDX'(k); s_we = 1; go();
      expect_v(0, S_BUSC, word, "R4");
      expect_v(1, S_IR, word, "R4");
      rexp[k] = word;
   endtask

   task automatic read_b(int r, string tag);
      clr(); s_rb = RIDX'(r); go();
      expect_v(0, S_BUSC, rexp[r], tag);
   endtask

   task automatic alu_chk(int op, int a, int b, logic [DW-1:0] v, string tag);
      clr(); s_ra = RIDX'(a); s_rb = RIDX'(b); s_op = 3'(op); go();
      expect_v(0, S_BUSC, v, tag);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem_w[i] = 32'h1357_9BDF * (i + 1) + 32'h0F0F_0001 * i;
      for (int i = 0; i < 8; i++) rexp[i] = '0;
      pc_e = '0; mdr_e = '0;
      clr();
      ra_idx = '0; rb_idx = '0; rc_idx = '0; rc_we = 0; pc_inc = 0; pc_ld = 0;
      mar_ld = 0; ir_ld = 0; mdr_ld_c = 0; mdr_ld_mem = 0; mem_rd = 0; mem_wr = 0;
      mem_done = 0; bsel = '0; alu_op = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      clr(); go();
      expect_v(0, S_PC, 0, "R1");
      expect_v(0, S_MAR, 0, "R1");
      expect_v(0, S_MDR, 0, "R1");
      expect_v(0, S_IR, 0, "R1");
      expect_v(0, S_REQ, 0, "R1");
      expect_v(0, S_STALL, 0, "R1");
      read_b(5, "R1");

      for (int k = 1; k < 8; k++) fetch_to(k);

      // R5 three-operand add in one step, then read back
      clr(); s_ra = 3'd5; s_rb = 3'd4; s_op = 3'd1; s_rc = 3'd6; s_we = 1; go();
      expect_v(0, S_BUSC, rexp[5] + rexp[4], "R5");
      rexp[6] = rexp[5] + rexp[4];
      read_b(6, "R5");

      // R6 remaining operations
      alu_chk(2, 1, 2, rexp[1] - rexp[2], "R6");
      alu_chk(3, 3, 7, rexp[3] & rexp[7], "R6");
      alu_chk(4, 3, 7, rexp[3] | rexp[7], "R6");
      alu_chk(5, 2, 6, rexp[2] ^ rexp[6], "R6");
      alu_chk(6, 1, 5, rexp[5], "R6");
      alu_chk(7, 1, 4, rexp[4], "R6");

      // R7 destination equals both sources: old value used
      clr(); s_ra = 3'd3; s_rb = 3'd3; s_op = 3'd1; s_rc = 3'd3; s_we = 1; go();
      expect_v(0, S_BUSC, rexp[3] + rexp[3], "R7");
      rexp[3] = rexp[3] + rexp[3];
      alu_chk(2, 3, 0, rexp[3], "R7");
      read_b(3, "R7");

      // R10 write enable low leaves entry untouched
      clr(); s_ra = 3'd1; s_rb = 3'd5; s_op = 3'd1; s_rc = 3'd2; s_we = 0; go();
      read_b(2, "R10");

      // R8 load wins over increment; instruction register on bus B
      clr(); s_rb = 3'd1; s_pld = 1; s_inc = 1; go();
      expect_v(1, S_PC, rexp[1], "R8");
      clr(); s_bsel = 2'd3; go();
      expect_v(0, S_BUSC, rexp[7], "R8");

      // R9 write access
      clr(); s_rb = 3'd5; s_mdrc = 1; go();
      expect_v(1, S_MDR, rexp[5], "R9");
      clr(); s_rb = 3'd2; s_mar = 1; s_wr = 1; go();
      expect_v(1, S_MAR, rexp[2], "R9");
      expect_v(1, S_REQ, 1, "R9");
      expect_v(1, S_WE, 1, "R9");
      clr(); go();
      expect_v(1, S_REQ, 1, "R9");
      clr(); s_done = 1; go();
      expect_v(1, S_REQ, 0, "R9");
      expect_v(1, S_WE, 0, "R9");
      expect_v(1, S_MDR, rexp[5], "R9");

      clr();
      repeat (3) go();
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule